// File: doc/BRIEF.md
# ARINC 429 Receive Bit Validator

This block recovers 32-bit ARINC 429 words from one receive lane. An external window comparator supplies three digital level indications: mark-one, mark-zero and null. The block samples them ten times per nominal bit. The sample strobe comes from the master clock divided by one of two ratios, selected by a speed input.

Each level feeds its own ten-sample history. From these histories the block decides whether a bit is well formed, whether successive bits are correctly spaced, and whether the line has been quiet long enough to start a new word. A word that breaks any rule is discarded without a trace at the outputs. The receiver then waits for a fresh inter-word gap.

A complete, valid word produces a one-clock end-of-sequence pulse. The recovered word appears on a holding output at the same time.

Top module: `a429_rx_validator`

## Requirements
- R1: A sample strobe fires once every HS_DIV master clocks while low_speed_i is 0, and once every LS_DIV master clocks while it is 1. Each of the three level inputs is captured exactly once per strobe.
- R2: A mark is recognised as a bit only once three consecutive samples show it. lvl_one_i gives bit value 1 and lvl_zero_i gives bit value 0. A mark shorter than three samples yields no bit, so the word it belongs to is dropped.
- R3: After a bit is recognised, a run of three consecutive null samples must be seen no later than 10 samples after recognition. Otherwise the word is dropped.
- R4: Recognition of a bit must come between 8 and 12 samples after recognition of the previous bit, inclusive. A spacing of 7 or of 13 drops the word.
- R5: A sample with lvl_one_i and lvl_zero_i both high drops the word in progress. This includes the first bit of a word.
- R6: While waiting for a gap, the newest ten samples are evaluated once every 10 strobes. A window passes when all ten samples are null and none shows a mark. Three passing windows in a row arm the receiver. A failing window, or a mark recognised while waiting, restarts the count.
- R6 (consequence): With bits made of 5 mark samples and 5 null samples, a word that follows the previous word after 4 further null bit times is accepted, and one that follows after only 3 is dropped.
- R7: When the 32nd bit is recognised, eos_o is high for exactly one master clock. At the same time word_o presents the word, with the first received bit in bit 0 and the 32nd in bit 31. word_o changes at no other time.
- R8: A dropped word produces no eos_o pulse and leaves word_o unchanged. A following word that is preceded by a valid gap is accepted.
- R9: Reset (rst_ni low) clears eos_o and word_o to 0 and leaves the receiver waiting for a gap. A word sent directly after reset, with no preceding gap, is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| low_speed_i | input | 1 | 0 selects divide by HS_DIV, 1 selects divide by LS_DIV |
| lvl_one_i | input | 1 | Comparator reports a mark-one level |
| lvl_zero_i | input | 1 | Comparator reports a mark-zero level |
| lvl_null_i | input | 1 | Comparator reports a null level |
| eos_o | output | 1 | One-clock pulse when a valid word completes |
| word_o | output | 32 | Last accepted word, first received bit in bit 0 |

## Verification
The checker watches several properties on every cycle:
- eos_o is a single-clock pulse that lands two clocks after a sample strobe.
- word_o moves only with eos_o.
- The sample histories change only on a strobe.
- The bit counter is zero outside word reception.
- The spacing counter never exceeds its upper limit while a word is in progress.

Whether a particular malformed word is actually rejected can only be shown by the bench's scenarios. These cover pulse width, spacing limits, a missing null, conflicting levels, gap length and speed selection, and the bench checks each outcome as the presence or absence of a pulse and the value held on word_o.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  typedef enum logic [1:0] {
    ST_GAP   = 2'd0,
    ST_ARMED = 2'd1,
    ST_WORD  = 2'd2
  } rx_state_e;

  localparam int unsigned NUM_LVL = 3;
  localparam int unsigned LVL_ONE  = 0;
  localparam int unsigned LVL_ZERO = 1;
  localparam int unsigned LVL_NULL = 2;
endpackage

// File: rtl/a429_rx_strobe.sv
module a429_rx_strobe #(
  parameter int unsigned HS_DIV = 10,
  parameter int unsigned LS_DIV = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_speed_i,
  output logic stb_o
);
  localparam int unsigned MAX_DIV = (LS_DIV > HS_DIV) ? LS_DIV : HS_DIV;
  localparam int unsigned CW = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
  localparam logic [CW-1:0] HS_LIM = CW'(HS_DIV - 1);
  localparam logic [CW-1:0] LS_LIM = CW'(LS_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim   = low_speed_i ? LS_LIM : HS_LIM;
  assign stb_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (stb_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/a429_rx_level_sr.sv
module a429_rx_level_sr #(
  parameter int unsigned LEN = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           stb_i,
  input  logic           lvl_i,
  output logic [LEN-1:0] sr_o
);
  // newest sample at bit 0, oldest at the top
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_o <= '0;
    else if (stb_i) sr_o <= {sr_o[LEN-2:0], lvl_i};
  end
endmodule

// File: rtl/a429_rx_gap_timer.sv
module a429_rx_gap_timer #(
  parameter int unsigned SPB    = 10,
  parameter int unsigned CHECKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic quiet_i,
  output logic armed_o
);
  localparam int unsigned PW = (SPB > 2) ? $clog2(SPB) : 1;
  localparam int unsigned KW = $clog2(CHECKS + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(SPB - 1);
  localparam logic [KW-1:0] K_DONE  = KW'(CHECKS);

  logic [PW-1:0] ph_q;
  logic [KW-1:0] k_q;

  assign armed_o = (k_q == K_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
      k_q  <= '0;
    end else if (clr_i) begin
      ph_q <= '0;
      k_q  <= '0;
    end else if (en_i) begin
      if (ph_q == PH_LAST) begin
        ph_q <= '0;
        if (!quiet_i) k_q <= '0;
        else if (!armed_o) k_q <= k_q + 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/a429_rx_validator.sv
module a429_rx_validator
  import a429_rx_pkg::*;
#(
  parameter int unsigned HS_DIV     = 10,
  parameter int unsigned LS_DIV     = 80,
  parameter int unsigned SPB        = 10,
  parameter int unsigned RUN        = 3,
  parameter int unsigned MIN_SP     = 8,
  parameter int unsigned MAX_SP     = 12,
  parameter int unsigned GAP_CHECKS = 3,
  parameter int unsigned WORD_BITS  = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 low_speed_i,
  input  logic                 lvl_one_i,
  input  logic                 lvl_zero_i,
  input  logic                 lvl_null_i,
  output logic                 eos_o,
  output logic [WORD_BITS-1:0] word_o
);
  localparam int unsigned SP_W = $clog2(MAX_SP + 2);
  localparam int unsigned BC_W = $clog2(WORD_BITS);
  localparam logic [SP_W-1:0] SP_MIN = SP_W'(MIN_SP);
  localparam logic [SP_W-1:0] SP_MAX = SP_W'(MAX_SP);
  localparam logic [SP_W-1:0] SP_BIT = SP_W'(SPB);
  localparam logic [SP_W-1:0] SP_SAT = SP_W'(MAX_SP + 1);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(WORD_BITS - 1);

  logic sample_stb;
  logic eval_q;

  a429_rx_strobe #(.HS_DIV(HS_DIV), .LS_DIV(LS_DIV)) u_stb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .low_speed_i(low_speed_i),
    .stb_o      (sample_stb)
  );

  logic [NUM_LVL-1:0] lvl_in;
  logic [SPB-1:0]     hist [NUM_LVL];
  assign lvl_in = {lvl_null_i, lvl_zero_i, lvl_one_i};

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_hist
    a429_rx_level_sr #(.LEN(SPB)) u_sr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .stb_i (sample_stb),
      .lvl_i (lvl_in[g]),
      .sr_o  (hist[g])
    );
  end

  logic [SPB-1:0] one_sr, zero_sr, null_sr;
  assign one_sr  = hist[LVL_ONE];
  assign zero_sr = hist[LVL_ZERO];
  assign null_sr = hist[LVL_NULL];

  // decode of the sample histories
  logic one_ev, zero_ev, bit_ev, bit_val, null_ok, quiet, conflict;
  assign one_ev   = (&one_sr[RUN-1:0])  && !one_sr[RUN];
  assign zero_ev  = (&zero_sr[RUN-1:0]) && !zero_sr[RUN];
  assign bit_ev   = one_ev | zero_ev;
  assign bit_val  = one_ev;
  assign null_ok  = &null_sr[RUN-1:0];
  assign quiet    = (&null_sr) && !(|(one_sr | zero_sr));
  assign conflict = one_sr[0] & zero_sr[0];

  rx_state_e            state_q;
  logic [BC_W-1:0]      bit_cnt_q;
  logic [SP_W-1:0]      sp_q;
  logic                 nul_seen_q;
  logic [WORD_BITS-2:0] shreg_q;
  logic [WORD_BITS-1:0] word_q;
  logic                 eos_q;

  logic [SP_W-1:0] sp_n;
  logic            nul_n, bit_bad, timeout;
  assign sp_n    = (sp_q == SP_SAT) ? sp_q : sp_q + 1'b1;
  assign nul_n   = nul_seen_q | null_ok;
  assign bit_bad = bit_ev && !(nul_seen_q && (sp_n >= SP_MIN) && (sp_n <= SP_MAX));
  assign timeout = !bit_ev && ((sp_n > SP_MAX) || ((sp_n >= SP_BIT) && !nul_n));

  logic gap_en, gap_clr, armed;
  assign gap_en  = eval_q && (state_q == ST_GAP);
  assign gap_clr = (state_q != ST_GAP) || (eval_q && (bit_ev || conflict));

  a429_rx_gap_timer #(.SPB(SPB), .CHECKS(GAP_CHECKS)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (gap_en),
    .clr_i  (gap_clr),
    .quiet_i(quiet),
    .armed_o(armed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_GAP;
      bit_cnt_q  <= '0;
      sp_q       <= '0;
      nul_seen_q <= 1'b0;
      shreg_q    <= '0;
      word_q     <= '0;
      eos_q      <= 1'b0;
      eval_q     <= 1'b0;
    end else begin
      eval_q <= sample_stb;
      eos_q  <= 1'b0;
      if (eval_q) begin
        unique case (state_q)
          ST_GAP: begin
            if (armed) state_q <= ST_ARMED;
          end
          ST_ARMED: begin
            if (conflict) begin
              state_q <= ST_GAP;
            end else if (bit_ev) begin
              state_q    <= ST_WORD;
              shreg_q    <= {bit_val, shreg_q[WORD_BITS-2:1]};
              bit_cnt_q  <= BC_W'(1);
              sp_q       <= '0;
              nul_seen_q <= 1'b0;
            end
          end
          ST_WORD: begin
            if (conflict || bit_bad || timeout) begin
              state_q   <= ST_GAP;
              bit_cnt_q <= '0;
              sp_q      <= '0;
            end else if (bit_ev) begin
              sp_q       <= '0;
              nul_seen_q <= 1'b0;
              if (bit_cnt_q == BC_LAST) begin
                word_q    <= {bit_val, shreg_q};
                eos_q     <= 1'b1;
                state_q   <= ST_GAP;
                bit_cnt_q <= '0;
              end else begin
                shreg_q   <= {bit_val, shreg_q[WORD_BITS-2:1]};
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end
            end else begin
              sp_q       <= sp_n;
              nul_seen_q <= nul_n;
            end
          end
          default: state_q <= ST_GAP;
        endcase
      end
    end
  end

  assign eos_o  = eos_q;
  assign word_o = word_q;
endmodule

// File: rtl/a429_rx_checker.sv
module a429_rx_checker #(
  parameter int unsigned SPB    = 10,
  parameter int unsigned WB     = 32,
  parameter int unsigned BC_W   = 5,
  parameter int unsigned SP_W   = 4,
  parameter int unsigned MAX_SP = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            stb_i,
  input logic            eos_i,
  input logic [WB-1:0]   word_i,
  input logic [SPB-1:0]  null_sr_i,
  input logic            in_word_i,
  input logic [BC_W-1:0] bit_cnt_i,
  input logic [SP_W-1:0] sp_i
);
  a_r7_eos_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_i |=> !eos_i);

  a_r1_eos_follows_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_i |-> $past(stb_i, 2));

  a_r7_word_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eos_i |-> $stable(word_i));

  a_r1_hist_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(null_sr_i));

  a_r8_count_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_word_i |-> (bit_cnt_i == '0));

  a_r4_spacing_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_word_i |-> (sp_i <= SP_W'(MAX_SP)));
endmodule

bind a429_rx_validator a429_rx_checker #(
  .SPB(SPB), .WB(WORD_BITS), .BC_W(BC_W), .SP_W(SP_W), .MAX_SP(MAX_SP)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .stb_i    (sample_stb),
  .eos_i    (eos_o),
  .word_i   (word_o),
  .null_sr_i(null_sr),
  .in_word_i(state_q == a429_rx_pkg::ST_WORD),
  .bit_cnt_i(bit_cnt_q),
  .sp_i     (sp_q)
);

// File: tb/a429_rx_validator_bench.sv
module a429_rx_validator_bench;
  localparam int HS = 2;
  localparam int LS = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic low_speed = 1'b0;
  logic l_one = 1'b0, l_zero = 1'b0, l_null = 1'b1;
  logic eos;
  logic [31:0] word;

  always #2 clk = ~clk;

  a429_rx_validator #(.HS_DIV(HS), .LS_DIV(LS)) u_a429_rx_validator (
    .clk_i(clk), .rst_ni(rst_ni), .low_speed_i(low_speed),
    .lvl_one_i(l_one), .lvl_zero_i(l_zero), .lvl_null_i(l_null),
    .eos_o(eos), .word_o(word)
  );

  int checks = 0, errors = 0;
  int div = HS;
  int eos_cnt = 0, run = 0, max_run = 0;
  logic [31:0] cap_word = '0;
  logic [31:0] last_good = '0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (rst_ni && eos) begin
      eos_cnt++;
      cap_word = word;
      run++;
      if (run > max_run) max_run = run;
    end else run = 0;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic smp(logic o, logic z, logic n);
    l_one = o; l_zero = z; l_null = n;
    repeat (div) @(negedge clk);
  endtask

  task automatic nulls(int cnt);
    for (int i = 0; i < cnt; i++) smp(1'b0, 1'b0, 1'b1);
  endtask

  task automatic send_bit(logic v, int d, int n, bit gl, bit cf);
    for (int i = 0; i < d; i++)
      if (i == 0 && cf) smp(1'b1, 1'b1, 1'b0);
      else smp(v, !v, 1'b0);
    for (int i = 0; i < n; i++)
      if (gl && i == 2) smp(v, !v, 1'b0);
      else smp(1'b0, 1'b0, 1'b1);
  endtask

  task automatic send_word(logic [31:0] w, int k, int d, int n, bit gl, bit cf);
    for (int b = 0; b < 32; b++)
      if (b == k) send_bit(w[b], d, n, gl, cf);
      else send_bit(w[b], 5, 5, 1'b0, 1'b0);
  endtask

  task automatic do_reset(logic ls, int dv);
    @(negedge clk);
    rst_ni = 1'b0; low_speed = ls; div = dv;
    l_one = 1'b0; l_zero = 1'b0; l_null = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  typedef struct packed {
    logic [31:0] w;
    logic [4:0]  k;
    logic [3:0]  d;
    logic [3:0]  n;
    logic        gl;
    logic        cf;
    logic        ok;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'hA5C3_0F96, 5'd0,  4'd5, 4'd5, 1'b0, 1'b0, 1'b1}, // R7 plain word
    '{32'h0000_0001, 5'd3,  4'd5, 4'd5, 1'b0, 1'b0, 1'b1}, // R7 bit order
    '{32'hFFFF_FFFF, 5'd5,  4'd3, 4'd5, 1'b0, 1'b0, 1'b1}, // R2 3-sample mark, R4 spacing 8
    '{32'h8000_0000, 5'd10, 4'd3, 4'd4, 1'b0, 1'b0, 1'b0}, // R4 spacing 7
    '{32'h1234_5678, 5'd12, 4'd5, 4'd7, 1'b0, 1'b0, 1'b1}, // R4 spacing 12
    '{32'h1234_5678, 5'd12, 4'd5, 4'd8, 1'b0, 1'b0, 1'b0}, // R4 spacing 13
    '{32'hDEAD_BEEF, 5'd7,  4'd2, 4'd8, 1'b0, 1'b0, 1'b0}, // R2 2-sample mark
    '{32'hCAFE_0042, 5'd20, 4'd9, 4'd3, 1'b0, 1'b0, 1'b1}, // R3 null found at 9
    '{32'hCAFE_0042, 5'd20, 4'd5, 4'd5, 1'b1, 1'b0, 1'b0}, // R3 null run broken
    '{32'h5555_AAAA, 5'd15, 4'd5, 4'd5, 1'b0, 1'b1, 1'b0}, // R5 conflict mid-word
    '{32'h0F0F_F0F0, 5'd31, 4'd5, 4'd5, 1'b0, 1'b0, 1'b1}, // R7 plain word
    '{32'h3C3C_3C3C, 5'd0,  4'd5, 4'd5, 1'b0, 1'b1, 1'b0}  // R5 conflict on first bit
  };

  function automatic string tag_of(int i);
    case (i)
      2, 6:       return "R2";
      7, 8:       return "R3";
      3, 4, 5:    return "R4";
      9, 11:      return "R5";
      default:    return "R7";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int e0;
    do_reset(1'b0, HS);
    // R9 reset state
    chk("R9 eos after reset", {31'd0, eos}, 32'd0);
    chk("R9 word after reset", word, 32'd0);
    // R9 word with no gap ahead of it
    e0 = eos_cnt;
    send_word(32'h7777_1111, 40, 5, 5, 1'b0, 1'b0);
    nulls(50);
    chk("R9 no-gap word dropped", eos_cnt - e0, 32'd0);

    for (int i = 0; i < NV; i++) begin
      nulls(40);
      e0 = eos_cnt;
      send_word(VECS[i].w, VECS[i].k, VECS[i].d, VECS[i].n, VECS[i].gl, VECS[i].cf);
      nulls(10);
      if (VECS[i].ok) begin
        chk({tag_of(i), " accepted count"}, eos_cnt - e0, 32'd1);
        chk({tag_of(i), " word value"}, cap_word, VECS[i].w);
        last_good = VECS[i].w;
      end else begin
        chk({tag_of(i), " dropped count"}, eos_cnt - e0, 32'd0);
        chk({"R8 word kept, vector ", tag_of(i)}, word, last_good);
      end
    end
    chk("R7 eos width", max_run, 32'd1);

    // R6 gap of 3 null bit times drops the next word
    nulls(40);
    e0 = eos_cnt;
    send_word(32'h1111_2222, 40, 5, 5, 1'b0, 1'b0);
    nulls(30);
    send_word(32'h3333_4444, 40, 5, 5, 1'b0, 1'b0);
    nulls(10);
    chk("R6 short gap count", eos_cnt - e0, 32'd1);
    chk("R6 short gap word", word, 32'h1111_2222);
    // R6 gap of 4 null bit times accepts the next word; R8 recovery
    nulls(40);
    e0 = eos_cnt;
    send_word(32'h5555_6666, 40, 5, 5, 1'b0, 1'b0);
    nulls(40);
    send_word(32'h7777_8888, 40, 5, 5, 1'b0, 1'b0);
    nulls(10);
    chk("R6 full gap count", eos_cnt - e0, 32'd2);
    chk("R6 full gap word", word, 32'h7777_8888);

    // R1 low-speed strobe with matching stimulus rate
    do_reset(1'b1, LS);
    nulls(40);
    e0 = eos_cnt;
    send_word(32'h0BAD_F00D, 40, 5, 5, 1'b0, 1'b0);
    nulls(10);
    chk("R1 low speed accepted", eos_cnt - e0, 32'd1);
    chk("R1 low speed word", word, 32'h0BAD_F00D);
    // R1 high-speed strobe sees slow stimulus as stretched bits
    do_reset(1'b0, LS);
    nulls(40);
    e0 = eos_cnt;
    send_word(32'h0BAD_F00D, 40, 5, 5, 1'b0, 1'b0);
    nulls(10);
    chk("R1 rate mismatch dropped", eos_cnt - e0, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule